// File: doc/BRIEF.md
# I2C Register-File Target

This block is the serial access point of a measurement front end. An I2C host reaches twelve byte-wide registers through it. Ten are read-only bytes that present five 12-bit conversion results. Two are read/write control bytes that drive the rest of the chip.

The block works from SCL and SDA samples that are already synchronised to the system clock. It recognises START, repeated START and STOP. It compares the 7-bit address with its own and loads a register pointer. It then carries out single or burst writes and reads, advancing the pointer after every byte. It pulls SDA low through an open-drain enable.

Two pre-decoded 2-bit pin codes select one of sixteen addresses. Reading the high byte of a result freezes the whole 12-bit value. The low byte fetched next therefore belongs to the same conversion, whether it follows in the same burst or after a repeated START.

Top module: `i2c_regfile_slave`

## Requirements
- R1: While rst_ni is low and right after it, sda_oe_o is 0 and both control outputs are 0x00.
- R2: The target address is 0x70 with its low four bits replaced by {addr_hi_code_i, addr_lo_code_i}, the low-pin code in bits 1:0. A matching address byte is acknowledged by SDA held low during the ninth clock.
- R3: An address byte that does not match gets no acknowledge. Every byte after it is ignored and SDA stays released until the next START.
- R4: In a write, the byte after the address loads the pointer. Each later byte is written to the pointed register, and the pointer then advances. Every byte is acknowledged.
- R5: The pointer advances from 0x0B to 0x00, for reads and writes alike.
- R6: A read is a pointer write, a repeated START, then the address with R/W=1. Bytes come MSB first from the pointer, which advances after each byte the host takes. After a host NACK, SDA is released.
- R7: Result k (result_i[12k+11:12k], k = 0..4) sits at pointer 2k and 2k+1. Its high byte is value[11:4]. Its low byte is {value[3:0], 4'b0000}.
- R8: Fetching a high byte at an even pointer below 0x0A captures that full 12-bit result. A low byte of the same result, read afterwards in the same burst or after a repeated START, returns the captured low nibble even if result_i has changed.
- R9: Writes to pointers 0x00 to 0x09 are acknowledged and leave the readable data unchanged.
- R10: Pointer 0x0A holds ctrl_main_o. Bit 4 is a one-shot: after a write with bit 4 set it is high for exactly one clock, then reads as 0. The other bits keep the written value.
- R11: Pointer 0x0B holds ctrl_time_o. Only bits 3 and 2 store the written value; the other bits stay 0.
- R12: sda_oe_o changes only while SCL is low. A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| addr_hi_code_i | input | 2 | Decoded level code of the high address pin |
| addr_lo_code_i | input | 2 | Decoded level code of the low address pin |
| result_i | input | 60 | Five 12-bit results, result k in bits 12k+11:12k |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ctrl_main_o | output | 8 | First control register |
| ctrl_time_o | output | 8 | Second control register, bits 3:2 only |

## Verification
On every cycle, the assertions check that the SDA enable moves only while SCL is low. They also check that a STOP leaves SDA released, that the one-shot control bit never lasts beyond one clock, and that the masked bits of the second control register stay zero. Only the bench scenarios can show the protocol-level behaviour. This covers address matching for each pin code, silence after a mismatch, pointer loading and wrap, and the byte layout of results. It also covers the captured low nibble when a result changes between its two bytes, both within a burst and across a repeated START.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam int unsigned RES_W    = 12;
  localparam int unsigned NUM_RES  = 5;
  localparam int unsigned PAIR_W   = $clog2(NUM_RES);
  localparam int unsigned RES_BYTES = 2 * NUM_RES;

  localparam logic [7:0] CTRL_MAIN_ADR  = 8'(RES_BYTES);
  localparam logic [7:0] CTRL_TIME_ADR  = 8'(RES_BYTES + 1);
  localparam logic [7:0] LAST_ADR       = CTRL_TIME_ADR;
  localparam logic [7:0] CTRL_TIME_MASK = 8'h0C;
  localparam int unsigned ONESHOT_BIT   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rx_kind_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/i2c_rf_cond.sv
module i2c_rf_cond
  import i2c_rf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges while SCL stays high are bus conditions
  assign ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
  assign ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
  assign ev_o.rise  = scl_i & ~scl_q;
  assign ev_o.fall  = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
  import i2c_rf_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_RES*RES_W-1:0] res_i,
  input  logic [7:0]               addr_i,
  input  logic                     wr_en_i,
  input  logic [7:0]               wdata_i,
  input  logic                     rd_en_i,
  output logic [7:0]               rdata_o,
  output logic [7:0]               ctrl_main_o,
  output logic [7:0]               ctrl_time_o
);
  logic [RES_W-1:0]  live [NUM_RES];
  logic [RES_W-1:0]  snap_q;
  logic [PAIR_W-1:0] snap_pair_q;
  logic              snap_vld_q;
  logic [PAIR_W-1:0] pair;
  logic              is_res;
  logic [7:0]        main_q, time_q;

  for (genvar k = 0; k < NUM_RES; k++) begin : g_unpack
    assign live[k] = res_i[k*RES_W +: RES_W];
  end

  assign pair   = addr_i[PAIR_W:1];
  assign is_res = (addr_i < 8'(RES_BYTES));

  always_comb begin
    rdata_o = '0;
    if (is_res) begin
      if (!addr_i[0])
        rdata_o = live[pair][RES_W-1 -: 8];
      else if (snap_vld_q && snap_pair_q == pair)
        rdata_o = {snap_q[RES_W-9:0], 4'h0};
      else
        rdata_o = {live[pair][RES_W-9:0], 4'h0};
    end else if (addr_i == CTRL_MAIN_ADR) begin
      rdata_o = main_q;
    end else if (addr_i == CTRL_TIME_ADR) begin
      rdata_o = time_q;
    end
  end

  // R8: high-byte fetch freezes the pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q      <= '0;
      snap_pair_q <= '0;
      snap_vld_q  <= 1'b0;
    end else if (rd_en_i && is_res && !addr_i[0]) begin
      snap_q      <= live[pair];
      snap_pair_q <= pair;
      snap_vld_q  <= 1'b1;
    end
  end

  // R9/R10/R11: only the two control addresses store
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      time_q <= '0;
    end else begin
      if (wr_en_i && addr_i == CTRL_MAIN_ADR) main_q <= wdata_i;
      else                                    main_q[ONESHOT_BIT] <= 1'b0;
      if (wr_en_i && addr_i == CTRL_TIME_ADR) time_q <= wdata_i & CTRL_TIME_MASK;
    end
  end

  assign ctrl_main_o = main_q;
  assign ctrl_time_o = time_q;
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bus_ev_t    ev_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] rdata_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic       rd_en_o,
  output logic [7:0] addr_o,
  output logic [7:0] wdata_o
);
  bus_state_e state_q;
  rx_kind_e   kind_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic [7:0] ptr_q;
  logic       is_read_q, host_ack_q, oe_q;
  logic       byte_in, load_tx;

  // R5
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return (p == LAST_ADR) ? 8'h00 : p + 8'h01;
  endfunction

  assign byte_in = (state_q == ST_RX) && ev_i.rise && (cnt_q == 4'd7);
  assign load_tx = ev_i.fall &&
                   (((state_q == ST_RX_ACK) && (kind_q == K_ADDR) && is_read_q) ||
                    ((state_q == ST_TX_ACK) && host_ack_q));

  assign wr_en_o  = byte_in && (kind_q == K_DATA);
  assign wdata_o  = {sh_q[6:0], sda_i};
  assign rd_en_o  = load_tx;
  assign addr_o   = ptr_q;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_ADDR;
      cnt_q      <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      is_read_q  <= 1'b0;
      host_ack_q <= 1'b0;
      oe_q       <= 1'b0;
    end else if (ev_i.start) begin
      state_q <= ST_RX;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (ev_i.stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_RX: begin
          if (ev_i.rise && cnt_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              unique case (kind_q)
                K_ADDR: begin
                  // R3: mismatch drops to idle, no ack
                  if (sh_q[6:0] == dev_addr_i) is_read_q <= sda_i;
                  else                         state_q   <= ST_IDLE;
                end
                K_PTR: begin
                  ptr_q  <= {sh_q[6:0], sda_i};
                  kind_q <= K_DATA;
                end
                default: ptr_q <= ptr_next(ptr_q);
              endcase
            end
          end else if (ev_i.fall && cnt_q == 4'd8) begin
            state_q <= ST_RX_ACK;
            oe_q    <= 1'b1;
          end
        end
        ST_RX_ACK: begin
          if (ev_i.fall) begin
            cnt_q <= '0;
            if (load_tx) begin
              state_q <= ST_TX;
              sh_q    <= rdata_i;
              oe_q    <= ~rdata_i[7];
              ptr_q   <= ptr_next(ptr_q);
            end else begin
              state_q <= ST_RX;
              oe_q    <= 1'b0;
              if (kind_q == K_ADDR) kind_q <= K_PTR;
            end
          end
        end
        ST_TX: begin
          if (ev_i.rise) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (ev_i.fall) begin
            if (cnt_q == 4'd8) begin
              state_q <= ST_TX_ACK;
              oe_q    <= 1'b0;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
              oe_q <= ~sh_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (ev_i.rise) begin
            host_ack_q <= ~sda_i;
          end else if (ev_i.fall) begin
            if (load_tx) begin
              state_q <= ST_TX;
              cnt_q   <= '0;
              sh_q    <= rdata_i;
              oe_q    <= ~rdata_i[7];
              ptr_q   <= ptr_next(ptr_q);
            end else begin
              state_q <= ST_IDLE; // R6: NACK, SDA stays released
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h70
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [1:0]               addr_hi_code_i,
  input  logic [1:0]               addr_lo_code_i,
  input  logic [NUM_RES*RES_W-1:0] result_i,
  output logic                     sda_oe_o,
  output logic [7:0]               ctrl_main_o,
  output logic [7:0]               ctrl_time_o
);
  bus_ev_t    ev;
  logic [6:0] dev_addr;
  logic       wr_en, rd_en;
  logic [7:0] addr, wdata, rdata;

  // R2
  assign dev_addr = BASE_ADDR | {3'b000, addr_hi_code_i, addr_lo_code_i};

  i2c_rf_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .ev_o   (ev)
  );

  i2c_rf_engine u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .sda_i      (sda_i),
    .dev_addr_i (dev_addr),
    .rdata_i    (rdata),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .rd_en_o    (rd_en),
    .addr_o     (addr),
    .wdata_o    (wdata)
  );

  i2c_rf_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_i       (result_i),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wdata_i     (wdata),
    .rd_en_i     (rd_en),
    .rdata_o     (rdata),
    .ctrl_main_o (ctrl_main_o),
    .ctrl_time_o (ctrl_time_o)
  );
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe_o,
  input logic [7:0] ctrl_main_o,
  input logic [7:0] ctrl_time_o
);
  // R12
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i));

  // R12
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe_o);

  // R10
  oneshot_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_main_o[4] |=> !ctrl_main_o[4]);

  // R11
  time_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_time_o & 8'hF3) == 8'h00);
endmodule

bind i2c_regfile_slave i2c_rf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_oe_o    (sda_oe_o),
  .ctrl_main_o (ctrl_main_o),
  .ctrl_time_o (ctrl_time_o)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] BASE = 7'h70;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic [1:0] hi_c = 2'd0, lo_c = 2'd0;
  logic [11:0] res_m [5];
  logic [59:0] res_flat;
  logic sda_oe;
  logic [7:0] ctrl_main, ctrl_time;
  wire sda_bus = sda_h & ~sda_oe;

  int total = 0, bad = 0, lr_cnt = 0;
  logic [7:0] m_main = 8'h00, m_time = 8'h00;
  logic [11:0] m_snap = 12'h000;
  int m_snap_pair = -1;

  for (genvar k = 0; k < 5; k++) begin : g_res
    assign res_flat[k*12 +: 12] = res_m[k];
  end

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (ctrl_main[4]) lr_cnt++;

  i2c_regfile_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .addr_hi_code_i(hi_c), .addr_lo_code_i(lo_c), .result_i(res_flat),
    .sda_oe_o(sda_oe), .ctrl_main_o(ctrl_main), .ctrl_time_o(ctrl_time));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] dev();
    return BASE | {3'b000, hi_c, lo_c};
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p == 8'h0B) ? 8'h00 : p + 8'h01;
  endfunction

  task automatic exp_rd(input logic [7:0] p, output logic [7:0] e);
    int pr;
    pr = int'(p) / 2;
    if (p < 8'd10) begin
      if (!p[0]) begin
        e = res_m[pr][11:4];
        m_snap = res_m[pr];
        m_snap_pair = pr;
      end else if (m_snap_pair == pr) e = {m_snap[3:0], 4'h0};
      else e = {res_m[pr][3:0], 4'h0};
    end else if (p == 8'h0A) e = m_main;
    else if (p == 8'h0B) e = m_time;
    else e = 8'h00;
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; half(); scl_h = 1'b1; half(); sda_h = 1'b0; half(); scl_h = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; half(); scl_h = 1'b1; half(); sda_h = 1'b1; half();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; half(); scl_h = 1'b1; half(); scl_h = 1'b0;
    end
    sda_h = 1'b1; half(); scl_h = 1'b1; half(); ack = ~sda_bus; scl_h = 1'b0; half();
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    sda_h = 1'b1; b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      half(); scl_h = 1'b1; half(); b = {b[6:0], sda_bus}; scl_h = 1'b0;
    end
    sda_h = ~ack; half(); scl_h = 1'b1; half(); scl_h = 1'b0; half(); sda_h = 1'b1;
  endtask

  // write burst; exp_ack=0 means the address must be refused
  task automatic wr_burst(input logic [6:0] a, input logic [7:0] p0, input int n,
                          input logic [7:0] d [4], input logic exp_ack, input string tag);
    logic ack;
    logic [7:0] p;
    p = p0;
    bus_start();
    wr_byte({a, 1'b0}, ack); chk({tag, " R2 addr ack"}, ack, exp_ack);
    wr_byte(p0, ack);        chk({tag, " R4 ptr ack"}, ack, exp_ack);
    for (int i = 0; i < n; i++) begin
      wr_byte(d[i], ack);    chk({tag, " R4 data ack"}, ack, exp_ack);
      if (exp_ack) begin
        if (p == 8'h0A) m_main = d[i] & 8'hEF;
        if (p == 8'h0B) m_time = d[i] & 8'h0C;
        p = nxt(p);
      end
    end
    bus_stop();
    chk({tag, " R12 idle oe"}, sda_oe, 1'b0);
    chk({tag, " R10 main"}, ctrl_main, m_main);
    chk({tag, " R11 time"}, ctrl_time, m_time);
  endtask

  task automatic rd_burst(input logic [7:0] p0, input int n, input string tag);
    logic ack;
    logic [7:0] b, e, p;
    p = p0;
    bus_start();
    wr_byte({dev(), 1'b0}, ack); chk({tag, " R2 ack"}, ack, 1'b1);
    wr_byte(p0, ack);           chk({tag, " R4 ptr ack"}, ack, 1'b1);
    bus_start();
    wr_byte({dev(), 1'b1}, ack); chk({tag, " R6 rd ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      exp_rd(p, e);
      rd_byte(i < n - 1, b);
      chk({tag, " R6 R7 data"}, b, e);
      p = nxt(p);
    end
    half();
    chk({tag, " R6 release after nack"}, sda_oe, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R12 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b, e;
    logic [7:0] d [4];
    int lr0;
    void'($urandom(32'd4711));
    for (int k = 0; k < 5; k++) res_m[k] = 12'(k * 12'h111 + 12'h0A5);
    repeat (5) @(negedge clk);
    // R1
    chk("R1 reset oe", sda_oe, 1'b0);
    chk("R1 reset main", ctrl_main, 8'h00);
    chk("R1 reset time", ctrl_time, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset oe", sda_oe, 1'b0);

    // R2: several pin codes
    for (int t = 0; t < 4; t++) begin
      hi_c = 2'($urandom_range(0, 3)); lo_c = 2'(t);
      d = '{8'($urandom), 8'h00, 8'h00, 8'h00};
      wr_burst(dev(), 8'h0B, 1, d, 1'b1, "R2 pin code");
    end
    hi_c = 2'd2; lo_c = 2'd1;

    // R3: wrong index and wrong base refused, following bytes ignored
    d = '{8'h55, 8'h0F, 8'h00, 8'h00};
    wr_burst(BASE | {3'b000, hi_c ^ 2'b01, lo_c}, 8'h0A, 2, d, 1'b0, "R3 wrong idx");
    wr_burst(7'h50 | {3'b000, hi_c, lo_c}, 8'h0A, 2, d, 1'b0, "R3 wrong base");

    // R4 R11: burst over both control registers
    d = '{8'hE3, 8'hFF, 8'h00, 8'h00};
    wr_burst(dev(), 8'h0A, 2, d, 1'b1, "R4 R11 burst");
    rd_burst(8'h0A, 2, "R4 readback");

    // R10: one-shot bit
    lr0 = lr_cnt;
    d = '{8'h1F, 8'h00, 8'h00, 8'h00};
    wr_burst(dev(), 8'h0A, 1, d, 1'b1, "R10 oneshot");
    chk("R10 oneshot cycles", lr_cnt - lr0, 1);

    // R5: wrap on write and on read
    d = '{8'h08, 8'h77, 8'h66, 8'h00};
    wr_burst(dev(), 8'h0B, 3, d, 1'b1, "R5 wrap wr");
    rd_burst(8'h0B, 3, "R5 wrap rd");

    // R9: read-only writes ignored
    d = '{8'h11, 8'h22, 8'h5A, 8'h00};
    wr_burst(dev(), 8'h08, 3, d, 1'b1, "R9 ro write");
    rd_burst(8'h08, 3, "R9 readback");

    // R7: all result bytes
    rd_burst(8'h00, 12, "R7 full");

    // R8: change inside a burst after high byte fetched
    bus_start();
    wr_byte({dev(), 1'b0}, ack); wr_byte(8'h02, ack);
    bus_start();
    wr_byte({dev(), 1'b1}, ack); chk("R8 rd ack", ack, 1'b1);
    exp_rd(8'h02, e);
    res_m[1] = res_m[1] ^ 12'h00F;
    rd_byte(1'b1, b); chk("R8 burst msb", b, e);
    exp_rd(8'h03, e);
    rd_byte(1'b0, b); chk("R8 burst lsb frozen", b, e);
    bus_stop();

    // R8: across a repeated START
    bus_start();
    wr_byte({dev(), 1'b0}, ack); wr_byte(8'h04, ack);
    bus_start();
    wr_byte({dev(), 1'b1}, ack);
    exp_rd(8'h04, e);
    rd_byte(1'b0, b); chk("R8 rs msb", b, e);
    res_m[2] = res_m[2] ^ 12'h00A;
    bus_start();
    wr_byte({dev(), 1'b0}, ack); wr_byte(8'h05, ack);
    bus_start();
    wr_byte({dev(), 1'b1}, ack);
    exp_rd(8'h05, e);
    rd_byte(1'b0, b); chk("R8 rs lsb frozen", b, e);
    half(); chk("R6 released", sda_oe, 1'b0);
    bus_stop();
    chk("R12 stop idle", sda_oe, 1'b0);

    // mixed random traffic
    for (int t = 0; t < 24; t++) begin
      for (int k = 0; k < 5; k++) res_m[k] = 12'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        d = '{8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
        wr_burst(dev(), 8'($urandom_range(0, 11)), int'($urandom_range(1, 4)), d, 1'b1, "R4 rand wr");
      end else begin
        rd_burst(8'($urandom_range(0, 11)), int'($urandom_range(1, 6)), "R7 rand rd");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule